// File: doc/BRIEF.md
# Three-Point Calibration and Output Coder

This block takes the raw result of a conversion filter for one channel and turns it into a calibrated output code. It removes the channel's zero-scale offset. It then scales the corrected value against one of two full-scale slopes, chosen by the sign of that value. It flags results that fall outside the calibrated span and codes the result as straight binary for a single-polarity range, or as offset binary or two's complement for a range of both polarities. Each channel has its own three 24-bit coefficients, held in an internal bank that a host can write and read directly.

A sample is tagged with a mode. A conversion sample is coded. A calibration sample instead captures a coefficient for its channel: zero-scale capture stores the raw value, and full-scale capture stores the distance from the stored offset. For that reason the offset is captured before either slope. A conversion result leaves the block a fixed two cycles after its sample, together with its channel index, so a result memory can store it directly.

Top module: `tri_point_cal`

## Requirements
- R1: After reset, every channel reads offset 000000h, positive slope 800000h and negative slope 800000h, and `out_valid` is low.
- R2: A host write with `cf_sel` 0 (offset), 1 (positive slope) or 2 (negative slope) stores `cf_wdata` for channel `cf_ch`, and `cf_rdata` returns it in the same cycle. Select 3 reads zero and its writes change nothing.
- R3: A sample with `in_mode` 1 (zero-scale capture) stores `in_raw` as the channel's offset.
- R4: `in_mode` 2 stores raw minus offset as the positive slope, and `in_mode` 3 stores offset minus raw as the negative slope, each kept to 24 bits. A capture wins over a host write to the same coefficient in the same cycle.
- R5: A conversion sample (`in_mode` 0) raises `out_valid` for one cycle exactly two clock edges after it is sampled, carrying its channel in `out_ch`. Calibration samples raise no `out_valid`.
- R6: Single-polarity mode (`in_bipolar` 0): with corrected value c = raw − offset and positive slope P, the code is round(c·65536/P), with halves rounded up. It is clamped to FFFFh when c equals P.
- R7: Bipolar mode: v = ±round(|c|·32768/G), with halves rounded away from zero, where G is P for c ≥ 0 and the negative slope N otherwise, and v is clamped to 7FFFh. `in_twos` 1 outputs v as two's complement, and `in_twos` 0 outputs v + 8000h.
- R8: When c > P, in either mode, `out_over` is set and the code saturates to FFFFh. The one exception is two's complement, where it saturates to 7FFFh.
- R9: Single-polarity mode: when c is negative, `out_under` is set and the code is 0000h.
- R10: Bipolar mode: when c < −N, `out_under` is set and the code is 8000h in two's complement or 0000h in offset binary. When c equals −N, no flag is set.
- R11: In single-polarity mode `in_twos` has no effect on the code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present |
| in_ch | input | 3 | Sample channel |
| in_mode | input | 2 | 0 convert, 1 zero-scale capture, 2 positive capture, 3 negative capture |
| in_bipolar | input | 1 | 1 selects the bipolar range |
| in_twos | input | 1 | 1 selects two's complement coding (bipolar only) |
| in_raw | input | 24 | Signed raw filter result |
| cf_we | input | 1 | Host coefficient write |
| cf_ch | input | 3 | Host coefficient channel |
| cf_sel | input | 2 | Host coefficient select |
| cf_wdata | input | 24 | Host write data |
| cf_rdata | output | 24 | Host read data |
| out_valid | output | 1 | Result present |
| out_ch | output | 3 | Result channel |
| out_code | output | 16 | Coded result |
| out_over | output | 1 | Over-range flag |
| out_under | output | 1 | Under-range flag |

## Verification
The bench builds the block with its defaults: eight channels, 24-bit coefficients and 16-bit codes. These settings put the exact span boundaries within reach. One channel keeps unity slopes, so the half-LSB rounding points and the largest raw value, which clamps without being flagged, can be hit directly. A second channel gets narrow, unequal slopes from the host, so c = P, c = P + 1, c = −N and c = −N − 1 can all be reached with 24-bit raw inputs. A third channel is calibrated through the capture modes, one of them colliding with a host write.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  typedef enum logic [1:0] {
    MODE_CONV = 2'd0,
    MODE_ZERO = 2'd1,
    MODE_PFS  = 2'd2,
    MODE_NFS  = 2'd3
  } samp_mode_e;

  typedef enum logic [1:0] {
    SEL_OFS  = 2'd0,
    SEL_PSL  = 2'd1,
    SEL_NSL  = 2'd2,
    SEL_NONE = 2'd3
  } coef_sel_e;
endpackage

// File: rtl/tpc_coef_bank.sv
module tpc_coef_bank
  import tpc_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int CW   = 24,
  localparam int CHW = $clog2(N_CH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_we,
  input  logic [CHW-1:0] host_ch,
  input  logic [1:0]     host_sel,
  input  logic [CW-1:0]  host_wdata,
  output logic [CW-1:0]  host_rdata,
  input  logic           cap_we,
  input  logic [CHW-1:0] cap_ch,
  input  logic [1:0]     cap_sel,
  input  logic [CW-1:0]  cap_data,
  input  logic [CHW-1:0] rd_ch,
  output logic [CW-1:0]  rd_ofs,
  output logic [CW-1:0]  rd_psl,
  output logic [CW-1:0]  rd_nsl
);
  localparam logic [CW-1:0] UNITY = {1'b1, {(CW-1){1'b0}}};

  logic [CW-1:0] ofs_q [N_CH];
  logic [CW-1:0] psl_q [N_CH];
  logic [CW-1:0] nsl_q [N_CH];
  logic [CW-1:0] ofs_d [N_CH];
  logic [CW-1:0] psl_d [N_CH];
  logic [CW-1:0] nsl_d [N_CH];
  logic          bank_en;

  assign bank_en = host_we | cap_we;

  // next state: host write first, capture second so capture wins
  always_comb begin
    ofs_d = ofs_q;
    psl_d = psl_q;
    nsl_d = nsl_q;
    if (host_we) begin
      case (host_sel)
        SEL_OFS: ofs_d[host_ch] = host_wdata;
        SEL_PSL: psl_d[host_ch] = host_wdata;
        SEL_NSL: nsl_d[host_ch] = host_wdata;
        default: ;
      endcase
    end
    if (cap_we) begin
      case (cap_sel)
        SEL_OFS: ofs_d[cap_ch] = cap_data;
        SEL_PSL: psl_d[cap_ch] = cap_data;
        SEL_NSL: nsl_d[cap_ch] = cap_data;
        default: ;
      endcase
    end
  end

  generate
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ofs_q[g] <= '0;
          psl_q[g] <= UNITY;
          nsl_q[g] <= UNITY;
        end else if (bank_en) begin
          ofs_q[g] <= ofs_d[g];
          psl_q[g] <= psl_d[g];
          nsl_q[g] <= nsl_d[g];
        end
      end
    end
  endgenerate

  always_comb begin
    case (host_sel)
      SEL_OFS: host_rdata = ofs_q[host_ch];
      SEL_PSL: host_rdata = psl_q[host_ch];
      SEL_NSL: host_rdata = nsl_q[host_ch];
      default: host_rdata = '0;
    endcase
  end

  assign rd_ofs = ofs_q[rd_ch];
  assign rd_psl = psl_q[rd_ch];
  assign rd_nsl = nsl_q[rd_ch];

  // R3
  zero_capture_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_we && cap_sel == SEL_OFS |=> ofs_q[$past(cap_ch)] == $past(cap_data));

  // R2
  host_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_we && host_sel == SEL_PSL && !(cap_we && cap_sel == SEL_PSL && cap_ch == host_ch)
    |=> psl_q[$past(host_ch)] == $past(host_wdata));
endmodule

// File: rtl/tpc_correct.sv
module tpc_correct
  import tpc_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int CW   = 24,
  localparam int CHW = $clog2(N_CH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [CHW-1:0] in_ch,
  input  logic [1:0]     in_mode,
  input  logic           in_bipolar,
  input  logic           in_twos,
  input  logic [CW-1:0]  in_raw,
  input  logic [CW-1:0]  co_ofs,
  input  logic [CW-1:0]  co_psl,
  input  logic [CW-1:0]  co_nsl,
  output logic           cap_we,
  output logic [1:0]     cap_sel,
  output logic [CW-1:0]  cap_data,
  output logic           s1_valid,
  output logic [CHW-1:0] s1_ch,
  output logic signed [CW:0] s1_corr,
  output logic [CW-1:0]  s1_gain,
  output logic           s1_bip,
  output logic           s1_twos,
  output logic           s1_over,
  output logic           s1_under
);
  logic              conv_go;
  logic signed [CW:0] corr_d;
  logic signed [CW:0] psl_s;
  logic signed [CW:0] nlim_s;
  logic              over_d;
  logic              under_d;
  logic [CW-1:0]     gain_d;

  assign conv_go = in_valid && (in_mode == MODE_CONV);
  assign corr_d  = $signed({in_raw[CW-1], in_raw}) - $signed({co_ofs[CW-1], co_ofs});
  assign psl_s   = $signed({1'b0, co_psl});
  assign nlim_s  = -$signed({1'b0, co_nsl});

  always_comb begin
    over_d  = corr_d > psl_s;
    under_d = in_bipolar ? (corr_d < nlim_s) : corr_d[CW];
    gain_d  = corr_d[CW] ? co_nsl : co_psl;
  end

  // capture path: calibration modes map onto coefficient selects 0..2
  always_comb begin
    cap_we  = in_valid && (in_mode != MODE_CONV);
    cap_sel = in_mode - 2'd1;
    case (in_mode)
      MODE_ZERO: cap_data = in_raw;
      MODE_PFS:  cap_data = corr_d[CW-1:0];
      default:   cap_data = co_ofs - in_raw;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_ch    <= '0;
      s1_corr  <= '0;
      s1_gain  <= '0;
      s1_bip   <= 1'b0;
      s1_twos  <= 1'b0;
      s1_over  <= 1'b0;
      s1_under <= 1'b0;
    end else begin
      s1_valid <= conv_go;
      if (conv_go) begin
        s1_ch    <= in_ch;
        s1_corr  <= corr_d;
        s1_gain  <= gain_d;
        s1_bip   <= in_bipolar;
        s1_twos  <= in_twos;
        s1_over  <= over_d;
        s1_under <= under_d;
      end
    end
  end

  // R5
  conv_enters_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_mode != MODE_CONV |=> !s1_valid);

  // R10
  under_is_negative_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && s1_under |-> s1_corr < 0);
endmodule

// File: rtl/tpc_coder.sv
module tpc_coder #(
  parameter int N_CH  = 8,
  parameter int CW    = 24,
  parameter int OUT_W = 16,
  localparam int CHW  = $clog2(N_CH),
  localparam int QW   = CW + OUT_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s1_valid,
  input  logic [CHW-1:0]     s1_ch,
  input  logic signed [CW:0] s1_corr,
  input  logic [CW-1:0]      s1_gain,
  input  logic               s1_bip,
  input  logic               s1_twos,
  input  logic               s1_over,
  input  logic               s1_under,
  output logic               out_valid,
  output logic [CHW-1:0]     out_ch,
  output logic [OUT_W-1:0]   out_code,
  output logic               out_over,
  output logic               out_under
);
  localparam logic [OUT_W-1:0] ALL1 = {OUT_W{1'b1}};
  localparam logic [OUT_W-1:0] PMAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NMIN = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic [QW-1:0]    UCAP = {{(QW-OUT_W){1'b0}}, ALL1};
  localparam logic [QW-1:0]    BCAP = {{(QW-OUT_W){1'b0}}, PMAX};

  logic [CW:0]        mag;
  logic [QW-1:0]      num;
  logic [QW-1:0]      den;
  logic [QW-1:0]      quo;
  logic [OUT_W-1:0]   sval;
  logic [OUT_W-1:0]   code_d;

  always_comb begin
    mag = s1_corr[CW] ? $unsigned(-s1_corr) : $unsigned(s1_corr);
    num = ({{(QW-CW-1){1'b0}}, mag} << (s1_bip ? OUT_W - 1 : OUT_W))
          + {{(QW-CW+1){1'b0}}, s1_gain[CW-1:1]};
    den = (s1_gain == '0) ? {{(QW-1){1'b0}}, 1'b1} : {{(QW-CW){1'b0}}, s1_gain};
    quo = num / den;
  end

  always_comb begin
    if (s1_corr[CW]) sval = ~quo[OUT_W-1:0] + 1'b1;
    else             sval = (quo > BCAP) ? PMAX : quo[OUT_W-1:0];
    if (s1_over)
      code_d = (s1_bip && s1_twos) ? PMAX : ALL1;
    else if (s1_under)
      code_d = (s1_bip && s1_twos) ? NMIN : '0;
    else if (!s1_bip)
      code_d = (quo > UCAP) ? ALL1 : quo[OUT_W-1:0];
    else
      code_d = s1_twos ? sval : (sval ^ NMIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_ch    <= '0;
      out_code  <= '0;
      out_over  <= 1'b0;
      out_under <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_ch    <= s1_ch;
        out_code  <= code_d;
        out_over  <= s1_over;
        out_under <= s1_under;
      end
    end
  end

  // R5
  stage_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid && out_ch == $past(s1_ch));

  // R8
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_over && out_under));
endmodule

// File: rtl/tri_point_cal.sv
module tri_point_cal #(
  parameter int N_CH  = 8,
  parameter int CW    = 24,
  parameter int OUT_W = 16,
  localparam int CHW  = $clog2(N_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [CHW-1:0]   in_ch,
  input  logic [1:0]       in_mode,
  input  logic             in_bipolar,
  input  logic             in_twos,
  input  logic [CW-1:0]    in_raw,
  input  logic             cf_we,
  input  logic [CHW-1:0]   cf_ch,
  input  logic [1:0]       cf_sel,
  input  logic [CW-1:0]    cf_wdata,
  output logic [CW-1:0]    cf_rdata,
  output logic             out_valid,
  output logic [CHW-1:0]   out_ch,
  output logic [OUT_W-1:0] out_code,
  output logic             out_over,
  output logic             out_under
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [CW-1:0]      co_ofs, co_psl, co_nsl;
  logic               cap_we;
  logic [1:0]         cap_sel;
  logic [CW-1:0]      cap_data;
  logic               s1_valid, s1_bip, s1_twos, s1_over, s1_under;
  logic [CHW-1:0]     s1_ch;
  logic signed [CW:0] s1_corr;
  logic [CW-1:0]      s1_gain;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  tpc_coef_bank #(.N_CH(N_CH), .CW(CW)) u_bank (
    .clk(clk), .rst_n(rst_int_n),
    .host_we(cf_we), .host_ch(cf_ch), .host_sel(cf_sel),
    .host_wdata(cf_wdata), .host_rdata(cf_rdata),
    .cap_we(cap_we), .cap_ch(in_ch), .cap_sel(cap_sel), .cap_data(cap_data),
    .rd_ch(in_ch), .rd_ofs(co_ofs), .rd_psl(co_psl), .rd_nsl(co_nsl)
  );

  tpc_correct #(.N_CH(N_CH), .CW(CW)) u_corr (
    .clk(clk), .rst_n(rst_int_n),
    .in_valid(in_valid), .in_ch(in_ch), .in_mode(in_mode),
    .in_bipolar(in_bipolar), .in_twos(in_twos), .in_raw(in_raw),
    .co_ofs(co_ofs), .co_psl(co_psl), .co_nsl(co_nsl),
    .cap_we(cap_we), .cap_sel(cap_sel), .cap_data(cap_data),
    .s1_valid(s1_valid), .s1_ch(s1_ch), .s1_corr(s1_corr), .s1_gain(s1_gain),
    .s1_bip(s1_bip), .s1_twos(s1_twos), .s1_over(s1_over), .s1_under(s1_under)
  );

  tpc_coder #(.N_CH(N_CH), .CW(CW), .OUT_W(OUT_W)) u_code (
    .clk(clk), .rst_n(rst_int_n),
    .s1_valid(s1_valid), .s1_ch(s1_ch), .s1_corr(s1_corr), .s1_gain(s1_gain),
    .s1_bip(s1_bip), .s1_twos(s1_twos), .s1_over(s1_over), .s1_under(s1_under),
    .out_valid(out_valid), .out_ch(out_ch), .out_code(out_code),
    .out_over(out_over), .out_under(out_under)
  );

  // R1
  idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> !out_valid);
endmodule

// File: tb/tb_tri_point_cal.sv
`timescale 1ns/1ps
module tb_tri_point_cal;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  in_ch;
  logic [1:0]  in_mode;
  logic        in_bipolar;
  logic        in_twos;
  logic [23:0] in_raw;
  logic        cf_we;
  logic [2:0]  cf_ch;
  logic [1:0]  cf_sel;
  logic [23:0] cf_wdata;
  logic [23:0] cf_rdata;
  logic        out_valid;
  logic [2:0]  out_ch;
  logic [15:0] out_code;
  logic        out_over;
  logic        out_under;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  tri_point_cal dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {ch, raw, bipolar, twos, code, over, under}
  localparam int NV = 25;
  localparam logic [46:0] VEC [NV] = '{
    {3'd0, 24'h400000, 1'b0, 1'b0, 16'h8000, 1'b0, 1'b0},  // R6
    {3'd0, 24'h000040, 1'b0, 1'b0, 16'h0001, 1'b0, 1'b0},  // R6 half up
    {3'd0, 24'h00003F, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0},  // R6
    {3'd0, 24'h7FFFFF, 1'b0, 1'b0, 16'hFFFF, 1'b0, 1'b0},  // R6 clamp
    {3'd0, 24'hFFFFFF, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1},  // R9
    {3'd0, 24'h400000, 1'b0, 1'b1, 16'h8000, 1'b0, 1'b0},  // R11
    {3'd0, 24'h400000, 1'b1, 1'b0, 16'hC000, 1'b0, 1'b0},  // R7
    {3'd0, 24'h400000, 1'b1, 1'b1, 16'h4000, 1'b0, 1'b0},  // R7
    {3'd0, 24'hC00000, 1'b1, 1'b1, 16'hC000, 1'b0, 1'b0},  // R7
    {3'd0, 24'hC00000, 1'b1, 1'b0, 16'h4000, 1'b0, 1'b0},  // R7
    {3'd0, 24'h800000, 1'b1, 1'b1, 16'h8000, 1'b0, 1'b0},  // R10 edge
    {3'd0, 24'h800000, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0},  // R10 edge
    {3'd0, 24'h000080, 1'b1, 1'b1, 16'h0001, 1'b0, 1'b0},  // R7 half
    {3'd0, 24'hFFFF80, 1'b1, 1'b1, 16'hFFFF, 1'b0, 1'b0},  // R7 half
    {3'd5, 24'h100100, 1'b0, 1'b0, 16'hFFFF, 1'b0, 1'b0},  // R6 c==P
    {3'd5, 24'h100101, 1'b0, 1'b0, 16'hFFFF, 1'b1, 1'b0},  // R8
    {3'd5, 24'h080100, 1'b0, 1'b0, 16'h8000, 1'b0, 1'b0},  // R6
    {3'd5, 24'h0000FF, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1},  // R9
    {3'd5, 24'h100101, 1'b1, 1'b1, 16'h7FFF, 1'b1, 1'b0},  // R8
    {3'd5, 24'h100101, 1'b1, 1'b0, 16'hFFFF, 1'b1, 1'b0},  // R8
    {3'd5, 24'hF80100, 1'b1, 1'b1, 16'h8000, 1'b0, 1'b0},  // R10 c==-N
    {3'd5, 24'hF800FF, 1'b1, 1'b1, 16'h8000, 1'b0, 1'b1},  // R10
    {3'd5, 24'hF800FF, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1},  // R10
    {3'd5, 24'hFC0100, 1'b1, 1'b0, 16'h4000, 1'b0, 1'b0},  // R7 N slope
    {3'd5, 24'h080100, 1'b1, 1'b1, 16'h4000, 1'b0, 1'b0}   // R7 P slope
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [2:0] ch, input logic [1:0] sel, input logic [23:0] d);
    @(negedge clk);
    cf_we = 1'b1; cf_ch = ch; cf_sel = sel; cf_wdata = d;
    @(negedge clk);
    cf_we = 1'b0;
  endtask

  task automatic host_read(input logic [2:0] ch, input logic [1:0] sel, output logic [23:0] d);
    @(negedge clk);
    cf_ch = ch; cf_sel = sel;
    #1 d = cf_rdata;
  endtask

  // drives one sample for one edge; returns at the falling edge after it
  task automatic send(input logic [2:0] ch, input logic [1:0] mode, input logic bip,
                      input logic twos, input logic [23:0] raw);
    @(negedge clk);
    in_valid = 1'b1; in_ch = ch; in_mode = mode;
    in_bipolar = bip; in_twos = twos; in_raw = raw;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic convert(input string req, input logic [2:0] ch, input logic bip,
                         input logic twos, input logic [23:0] raw,
                         input logic [15:0] code, input logic ov, input logic un);
    send(ch, 2'd0, bip, twos, raw);
    check("R5 not early", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    check("R5 valid", {31'd0, out_valid}, 32'd1);
    check("R5 channel", {29'd0, out_ch}, {29'd0, ch});
    check(req, {16'd0, out_code}, {16'd0, code});
    check({req, " over"}, {31'd0, out_over}, {31'd0, ov});
    check({req, " under"}, {31'd0, out_under}, {31'd0, un});
    @(negedge clk);
    check("R5 one cycle", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [23:0] rd;
    in_valid = 0; in_ch = 0; in_mode = 0; in_bipolar = 0; in_twos = 0; in_raw = 0;
    cf_we = 0; cf_ch = 0; cf_sel = 0; cf_wdata = 0;
    rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    host_read(3'd7, 2'd0, rd); check("R1 offset", {8'd0, rd}, 32'h000000);
    host_read(3'd7, 2'd1, rd); check("R1 pos slope", {8'd0, rd}, 32'h800000);
    host_read(3'd7, 2'd2, rd); check("R1 neg slope", {8'd0, rd}, 32'h800000);

    // R2 host port on channel 5
    host_write(3'd5, 2'd0, 24'h000100);
    host_write(3'd5, 2'd1, 24'h100000);
    host_write(3'd5, 2'd2, 24'h080000);
    host_write(3'd5, 2'd3, 24'hABCDEF);
    host_read(3'd5, 2'd0, rd); check("R2 offset", {8'd0, rd}, 32'h000100);
    host_read(3'd5, 2'd1, rd); check("R2 pos", {8'd0, rd}, 32'h100000);
    host_read(3'd5, 2'd2, rd); check("R2 neg", {8'd0, rd}, 32'h080000);
    host_read(3'd5, 2'd3, rd); check("R2 select 3", {8'd0, rd}, 32'h000000);
    host_read(3'd4, 2'd1, rd); check("R2 other channel", {8'd0, rd}, 32'h800000);

    // R3 and R4: zero-scale capture colliding with a host write on channel 2
    @(negedge clk);
    cf_we = 1'b1; cf_ch = 3'd2; cf_sel = 2'd0; cf_wdata = 24'h123456;
    in_valid = 1'b1; in_ch = 3'd2; in_mode = 2'd1; in_raw = 24'h000200;
    in_bipolar = 0; in_twos = 0;
    @(negedge clk);
    cf_we = 1'b0; in_valid = 1'b0;
    check("R5 capture silent", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    check("R5 capture silent", {31'd0, out_valid}, 32'd0);
    host_read(3'd2, 2'd0, rd); check("R3 R4 capture wins", {8'd0, rd}, 32'h000200);
    send(3'd2, 2'd2, 1'b0, 1'b0, 24'h200200);
    host_read(3'd2, 2'd1, rd); check("R4 pos capture", {8'd0, rd}, 32'h200000);
    send(3'd2, 2'd3, 1'b0, 1'b0, 24'hF00200);
    host_read(3'd2, 2'd2, rd); check("R4 neg capture", {8'd0, rd}, 32'h100000);
    convert("R4 R6 captured P", 3'd2, 1'b0, 1'b0, 24'h100200, 16'h8000, 1'b0, 1'b0);
    convert("R4 R7 captured N", 3'd2, 1'b1, 1'b1, 24'hF80200, 16'hC000, 1'b0, 1'b0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      convert($sformatf("vector %0d", i), VEC[i][46:44], VEC[i][19], VEC[i][18],
              VEC[i][43:20], VEC[i][17:2], VEC[i][1], VEC[i][0]);
    end

    // R1 again: reset restores defaults on channel 5
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    host_read(3'd5, 2'd1, rd); check("R1 reset restores slope", {8'd0, rd}, 32'h800000);
    host_read(3'd5, 2'd0, rd); check("R1 reset clears offset", {8'd0, rd}, 32'h000000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule